// File: doc/BRIEF.md
# Signed Up/Down Conversion Counter with Rectified Output

This block is the digital end of a column ramp converter, used to produce a signed weighted sum with an offset term and a rectified result. Before a conversion it takes a signed preset (the batch-normalisation offset). Each ramp window then moves a counter by one per clock, up or down, until the comparator reports that the ramp has passed the analog level. In the first window the counter runs upward for the positive-weight sum. In the second it runs downward for the negative-weight sum. The counter therefore ends at offset + positive − negative.

When a down-counting window closes, the block latches the accumulated value as an unsigned DATA_W-bit result. Negative sums become zero, and sums above the largest code become the all-ones code. A one-cycle valid strobe marks the new result. The comparator is asynchronous to the counter clock, so it passes through a synchroniser of SYNC_STAGES flops. Inside a window, the first synchronised high level ends counting for the rest of that window.

Top module: `cds_relu_counter`

## Requirements
- R1: After reset, `result` is 0 and `result_valid` is 0.
- R2: A `preset_load` strobe is accepted only while the block is idle, meaning after reset or after a result has been latched. It loads `preset_value`, read as a (DATA_W+1)-bit two's-complement number, into the counter. A strobe that arrives after an accepted preset, before the next result, has no effect on the result.
- R3: A window opens on the first clock edge at which `ramp_active` is seen high after having been low. On each later edge of an up window (`phase_down` = 0 at the opening edge), the counter adds one as long as the synchronised comparator is still low. The synchroniser delays `comp_in` by SYNC_STAGES edges. If `comp_in` is raised before edge k of the window, the window contributes k−1+SYNC_STAGES counts, subject to R6.
- R4: A down window (`phase_down` = 1 at the opening edge) follows the same stop rule, but subtracts one per counted edge.
- R5: Once the synchronised comparator has been high inside a window, counting stays stopped for the rest of that window, even if `comp_in` falls again.
- R6: A window closes at the first edge where `ramp_active` is low, or after 2^DATA_W window edges, whichever comes first. A window therefore contributes at most 2^DATA_W counts.
- R7: When a down window closes, the counter value is latched into `result`. Up windows only accumulate, so several up windows may come before the down window. A down window that comes first latches at once.
- R8: A negative counter value is latched as 0.
- R9: A counter value above 2^DATA_W−1 is latched as 2^DATA_W−1.
- R10: `result_valid` is high for exactly one cycle per latch, and `result` holds its value between latches.
- R11: While idle, ramp windows are ignored: they neither count nor produce a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| preset_load | input | 1 | Strobe that loads the offset preset |
| preset_value | input | DATA_W+1 | Signed offset preset |
| ramp_active | input | 1 | High while the ramp is running (the conversion window) |
| phase_down | input | 1 | Sample phase select: 0 counts up, 1 counts down |
| comp_in | input | 1 | Asynchronous comparator output |
| result | output | DATA_W | Rectified, saturated latched result |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
A wrong internal count never shows at the ports until the end of the down window. It only appears as a wrong `result` in the cycle that `result_valid` pulses, which can be up to two full windows after the fault. For this reason the bench rebuilds every counted edge in its own model and compares valid and result on every cycle. Each scenario's final value is also derived by hand from the crossing positions. A stuck stop flag, a wrong synchroniser depth or a missing window cap changes the latched value by a predictable number of codes. A broken clamp or saturation path only shows when the sum crosses zero or exceeds the top code, so both cases are driven on purpose.

// File: rtl/cds_relu_pkg.sv
package cds_relu_pkg;

   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_ARMED = 1'b1
   } cds_state_e;

endpackage

// File: rtl/cds_comp_sync.sv
module cds_comp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic comp_in,
   output logic comp_q
);

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("cds_comp_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= comp_in;
         end
         assign comp_q = q;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], comp_in};
         end
         assign comp_q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/cds_window_ctrl.sv
module cds_window_ctrl #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = DATA_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             ramp_active,
   input  logic             phase_down,
   input  logic             comp_q,
   output logic             count_en,
   output logic             count_dir,
   output logic             close_down,
   output logic             win_open,
   output logic             stopped,
   output logic [CNT_W-1:0] win_cnt
);

   localparam logic [CNT_W-1:0] WIN_LEN = CNT_W'(1) << DATA_W;

   logic             ramp_prev;
   logic             win_q;
   logic             dir_q;
   logic             stop_q;
   logic [CNT_W-1:0] cnt_q;
   logic             start;
   logic             close;

   // A window opens only on a rising ramp, so a capped window cannot reopen
   // while the ramp is still high.
   assign start = armed & ramp_active & ~ramp_prev & ~win_q;
   assign close = win_q & (~ramp_active | (cnt_q == WIN_LEN));

   assign count_en   = win_q & ~close & ~stop_q & ~comp_q;
   assign count_dir  = dir_q;
   assign close_down = close & dir_q;
   assign win_open   = win_q;
   assign stopped    = stop_q;
   assign win_cnt    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ramp_prev <= 1'b0;
         win_q     <= 1'b0;
         dir_q     <= 1'b0;
         stop_q    <= 1'b0;
         cnt_q     <= '0;
      end else begin
         ramp_prev <= ramp_active;
         if (start) begin
            win_q  <= 1'b1;
            dir_q  <= phase_down;
            stop_q <= 1'b0;
            cnt_q  <= '0;
         end else if (close) begin
            win_q <= 1'b0;
         end else if (win_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (comp_q) stop_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/cds_updown_acc.sv
module cds_updown_acc #(
   parameter int unsigned ACC_W = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic signed [ACC_W-1:0] load_val,
   input  logic                    step_en,
   input  logic                    step_down,
   output logic signed [ACC_W-1:0] acc
);

   localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (load) begin
         acc <= load_val;
      end else if (step_en) begin
         if (step_down) begin
            if (acc != ACC_MIN) acc <= acc - 1'b1;
         end else begin
            if (acc != ACC_MAX) acc <= acc + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cds_relu_latch.sv
module cds_relu_latch #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ACC_W  = DATA_W + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    latch_en,
   input  logic signed [ACC_W-1:0] acc,
   output logic [DATA_W-1:0]       result,
   output logic                    result_valid
);

   localparam logic signed [ACC_W-1:0] TOP_CODE = ACC_W'((64'd1 << DATA_W) - 64'd1);

   logic [DATA_W-1:0] clamped;

   always_comb begin
      if (acc[ACC_W-1])        clamped = '0;
      else if (acc > TOP_CODE) clamped = '1;
      else                     clamped = acc[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result       <= '0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= latch_en;
         if (latch_en) result <= clamped;
      end
   end

endmodule

// File: rtl/cds_relu_counter.sv
module cds_relu_counter
   import cds_relu_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              preset_load,
   input  logic [DATA_W:0]   preset_value,
   input  logic              ramp_active,
   input  logic              phase_down,
   input  logic              comp_in,
   output logic [DATA_W-1:0] result,
   output logic              result_valid
);

   localparam int unsigned ACC_W = DATA_W + 2;
   localparam int unsigned CNT_W = DATA_W + 1;

   generate
      if (DATA_W < 2 || DATA_W > 24) begin : g_bad_width
         $error("cds_relu_counter: DATA_W out of range 2..24");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("cds_relu_counter: SYNC_STAGES out of range 1..4");
      end
   endgenerate

   cds_state_e              state_q;
   logic                    st_idle;
   logic                    load_accept;
   logic                    comp_q;
   logic                    count_en;
   logic                    count_dir;
   logic                    latch_en;
   logic                    win_open;
   logic                    stopped;
   logic [CNT_W-1:0]        win_cnt;
   logic signed [ACC_W-1:0] preset_ext;
   logic signed [ACC_W-1:0] acc;

   assign st_idle     = (state_q == ST_IDLE);
   assign load_accept = st_idle & preset_load;
   assign preset_ext  = {{(ACC_W-DATA_W-1){preset_value[DATA_W]}}, preset_value};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           state_q <= ST_IDLE;
      else if (load_accept) state_q <= ST_ARMED;
      else if (latch_en)    state_q <= ST_IDLE;
   end

   cds_comp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .comp_in (comp_in),
      .comp_q  (comp_q)
   );

   cds_window_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .armed       (~st_idle),
      .ramp_active (ramp_active),
      .phase_down  (phase_down),
      .comp_q      (comp_q),
      .count_en    (count_en),
      .count_dir   (count_dir),
      .close_down  (latch_en),
      .win_open    (win_open),
      .stopped     (stopped),
      .win_cnt     (win_cnt)
   );

   cds_updown_acc #(.ACC_W(ACC_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_accept),
      .load_val  (preset_ext),
      .step_en   (count_en),
      .step_down (count_dir),
      .acc       (acc)
   );

   cds_relu_latch #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .latch_en     (latch_en),
      .acc          (acc),
      .result       (result),
      .result_valid (result_valid)
   );

endmodule

// File: rtl/cds_relu_counter_chk.sv
module cds_relu_counter_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ACC_W  = DATA_W + 2,
   parameter int unsigned CNT_W  = DATA_W + 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [DATA_W:0]         preset_value,
   input logic                    st_idle,
   input logic                    load_accept,
   input logic                    count_en,
   input logic                    win_open,
   input logic                    stopped,
   input logic [CNT_W-1:0]        win_cnt,
   input logic signed [ACC_W-1:0] acc,
   input logic                    latch_en,
   input logic [DATA_W-1:0]       result,
   input logic                    result_valid
);

   localparam logic [CNT_W-1:0]        WIN_LEN  = CNT_W'(1) << DATA_W;
   localparam logic signed [ACC_W-1:0] TOP_CODE = ACC_W'((64'd1 << DATA_W) - 64'd1);

   logic signed [ACC_W-1:0] preset_ext;
   logic [DATA_W-1:0]       acc_low;

   assign preset_ext = {{(ACC_W-DATA_W-1){preset_value[DATA_W]}}, preset_value};
   assign acc_low    = acc[DATA_W-1:0];

   p_preset_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_accept |=> acc == $past(preset_ext));

   p_acc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_accept && !count_en) |=> $stable(acc));

   p_stop_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && win_open) |=> stopped);

   p_window_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> win_cnt <= WIN_LEN);

   p_idle_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st_idle |-> !win_open);

   p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && !acc[ACC_W-1] && acc <= TOP_CODE) |=> result == $past(acc_low));

   p_clamp_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && acc[ACC_W-1]) |=> (result == '0) && result_valid);

   p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && !acc[ACC_W-1] && acc > TOP_CODE) |=> result == '1);

   p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> $stable(result));

endmodule

bind cds_relu_counter cds_relu_counter_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .preset_value (preset_value),
   .st_idle      (st_idle),
   .load_accept  (load_accept),
   .count_en     (count_en),
   .win_open     (win_open),
   .stopped      (stopped),
   .win_cnt      (win_cnt),
   .acc          (acc),
   .latch_en     (latch_en),
   .result       (result),
   .result_valid (result_valid)
);

// File: tb/cds_relu_counter_test.sv
module cds_relu_counter_test;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int SYNC       = 2;
   localparam int WIN        = 1 << DATA_W;
   localparam int TOP        = WIN - 1;
   localparam int ACC_MAX    = (1 << (DATA_W + 1)) - 1;
   localparam int ACC_MIN    = -(1 << (DATA_W + 1));
   localparam int WATCHDOG   = 30000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              preset_load = 1'b0;
   logic [DATA_W:0]   preset_value = '0;
   logic              ramp_active = 1'b0;
   logic              phase_down = 1'b0;
   logic              comp_in = 1'b0;
   logic [DATA_W-1:0] result;
   logic              result_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   cds_relu_counter #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .preset_load  (preset_load),
      .preset_value (preset_value),
      .ramp_active  (ramp_active),
      .phase_down   (phase_down),
      .comp_in      (comp_in),
      .result       (result),
      .result_valid (result_valid)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   int cycles   = 0;

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // Behavioural reference model, updated at every rising edge.
   int m_acc = 0;
   bit m_armed = 1'b0;
   bit m_win = 1'b0;
   bit m_dir = 1'b0;
   int m_wcnt = 0;
   bit m_stop = 1'b0;
   bit m_rprev = 1'b0;
   int m_result = 0;
   bit m_valid = 1'b0;
   bit comp_hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_armed = 0; m_win = 0; m_dir = 0; m_wcnt = 0;
         m_stop = 0; m_rprev = 0; m_result = 0; m_valid = 0;
         comp_hist.delete();
      end else begin
         bit synced;
         bit was_idle;
         was_idle = !m_armed;
         synced = (comp_hist.size() >= SYNC) ? comp_hist[SYNC-1] : 1'b0;
         comp_hist.push_front(comp_in);
         if (comp_hist.size() > SYNC) void'(comp_hist.pop_back());
         m_valid = 0;
         if (m_win) begin
            if (!ramp_active || m_wcnt == WIN) begin
               m_win = 0;
               if (m_dir) begin
                  m_result = (m_acc < 0) ? 0 : ((m_acc > TOP) ? TOP : m_acc);
                  m_valid  = 1;
                  m_armed  = 0;
               end
            end else begin
               if (synced) m_stop = 1;
               else if (!m_stop) begin
                  if (m_dir) m_acc = (m_acc > ACC_MIN) ? m_acc - 1 : m_acc;
                  else       m_acc = (m_acc < ACC_MAX) ? m_acc + 1 : m_acc;
               end
               m_wcnt++;
            end
         end else if (m_armed && ramp_active && !m_rprev) begin
            m_win = 1; m_dir = phase_down; m_wcnt = 0; m_stop = 0;
         end
         if (was_idle && preset_load) begin
            m_acc   = int'($signed(preset_value));
            m_armed = 1;
         end
         m_rprev = ramp_active;
      end
   end

   // Per-cycle comparison and result capture, away from the active edge.
   int valid_count = 0;
   int vc_mark = 0;
   int last_res = 0;
   bit prev_valid = 1'b0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R7 cycle result vs model", int'(result), m_result);
         check("R10 cycle valid vs model", int'(result_valid), int'(m_valid));
         if (result_valid) begin
            valid_count++;
            last_res = int'(result);
            if (prev_valid) check("R10 valid longer than one cycle", 1, 0);
         end
         prev_valid = result_valid;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   function automatic int cnt(int cross_at, int len);
      int c;
      if (cross_at < 0) return 0;
      c = cross_at + SYNC;
      if (c > len) c = len;
      if (c > WIN) c = WIN;
      return c;
   endfunction

   task automatic load_preset(int v);
      @(negedge clk);
      preset_load  = 1'b1;
      preset_value = v[DATA_W:0];
      @(negedge clk);
      preset_load = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // cross_at < 0: comparator already high when the window opens.
   task automatic run_window(bit down, int cross_at, int len, int glitch_at);
      @(negedge clk);
      phase_down = down;
      comp_in    = 1'b0;
      if (cross_at < 0) begin
         comp_in = 1'b1;
         repeat (4) @(negedge clk);
      end
      ramp_active = 1'b1;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (i == cross_at) comp_in = 1'b1;
         if (glitch_at >= 0 && i == glitch_at) comp_in = 1'b0;
      end
      @(negedge clk);
      ramp_active = 1'b0;
      comp_in     = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_result(string req, int exp);
      check({req, " one valid strobe"}, valid_count - vc_mark, 1);
      check({req, " latched value"}, last_res, exp);
      vc_mark = valid_count;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 result in reset", int'(result), 0);
      check("R1 valid in reset", int'(result_valid), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 result after reset", int'(result), 0);

      // R11: windows with no preset are ignored
      run_window(1'b0, 10, 30, -1);
      run_window(1'b1, 5, 30, -1);
      check("R11 no strobe while idle", valid_count - vc_mark, 0);
      check("R11 result unchanged while idle", int'(result), 0);

      // R3 R4: basic up then down
      load_preset(10);
      run_window(1'b0, 40, 100, -1);
      run_window(1'b1, 20, 100, -1);
      expect_result("R3 R4 basic", 10 + cnt(40, 100) - cnt(20, 100));
      repeat (20) @(negedge clk);
      check("R10 result held", int'(result), 30);

      // R2: negative preset
      load_preset(-20);
      run_window(1'b0, 60, 100, -1);
      run_window(1'b1, 5, 100, -1);
      expect_result("R2 negative preset", -20 + cnt(60, 100) - cnt(5, 100));

      // R8: negative sum clamps to zero
      load_preset(5);
      run_window(1'b0, 10, 50, -1);
      run_window(1'b1, 40, 60, -1);
      expect_result("R8 clamp", 0);

      // R9: saturation at top code
      load_preset(200);
      run_window(1'b0, 100, 150, -1);
      run_window(1'b1, -1, 10, -1);
      expect_result("R9 saturate", TOP);

      // R6: window capped at 2^DATA_W counts
      load_preset(-100);
      run_window(1'b0, 1000, 300, -1);
      run_window(1'b1, -1, 10, -1);
      expect_result("R6 window cap", -100 + WIN);

      // R5: comparator drop after crossing is ignored
      load_preset(0);
      run_window(1'b0, 30, 80, 33);
      run_window(1'b1, -1, 10, -1);
      expect_result("R5 sticky stop", cnt(30, 80));

      // R2: second preset while armed is ignored
      load_preset(50);
      load_preset(7);
      run_window(1'b0, 10, 40, -1);
      run_window(1'b1, -1, 10, -1);
      expect_result("R2 preset ignored", 50 + cnt(10, 40));

      // R7: down window first latches at once
      load_preset(40);
      run_window(1'b1, 10, 40, -1);
      expect_result("R7 down first", 40 - cnt(10, 40));

      // R7: two up windows accumulate
      load_preset(0);
      run_window(1'b0, 10, 40, -1);
      run_window(1'b0, 5, 40, -1);
      run_window(1'b1, -1, 10, -1);
      expect_result("R7 two up windows", cnt(10, 40) + cnt(5, 40));

      // R6: ramp ending early closes the window
      load_preset(0);
      run_window(1'b0, 1000, 20, -1);
      run_window(1'b1, -1, 10, -1);
      expect_result("R6 short window", 20);

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule